// File: doc/BRIEF.md
# Vectored Interrupt Mapper and Dispatcher

This block collects 64 level-sensitive interrupt lines. Lines 0 to 31 come from expansion-bus slots and lines 32 to 63 from on-board devices. Each slot line is gated by the enable of the map register for its group of four. Each on-board line is gated by its own map register. The block holds a single outstanding request. That request is a source number, or an empty marker. The block raises exactly the one vector output line whose index equals that number.

Software reaches the block through a simple register port. It writes map registers to enable or disable sources. It writes clear registers to retire the outstanding request, and it reads map registers back. A cleared or disabled request frees the slot, and the dispatcher rescans the pending lines on the following cycle. A slot line that rises while its group is enabled takes the slot over at once, even from an outstanding request. An on-board line that rises waits until the slot is empty.

Top module: `irq_vector_dispatch`

## Requirements
- R1: Reset clears every enable, the pending lines and the request, so all vector outputs are low. Slot map register g then reads (0x1F<<6)|(g<<2), and on-board map register b reads 0x7E0+b.
- R2: A map register write changes only bit 31, which is the enable. All other read-back bits keep their reset pattern whatever the write data.
- R3: At most one vector output is high at any time. Output n is high exactly when the outstanding request is source n.
- R4: An enabled line that is asserted while the slot is empty drives its vector output from the second rising edge after it is sampled high. A line whose enable is 0 never drives an output.
- R5: When the slot is empty, the lowest-numbered asserted and enabled line is taken. Every slot line (0..31) is therefore taken before any on-board line (32..63).
- R6: A slot line that newly rises while its group is enabled replaces an outstanding request.
- R7: An on-board line that newly rises never replaces an outstanding request.
- R8: A request stays outstanding until it is cleared, even after its line drops.
- R9: A write to slot clear address 0x1400+32*g clears the request when the request is a slot source with number/4 == g. Slot clear writes for other groups leave the request unchanged.
- R10: A write to on-board clear address 0x1800+8*b clears the request when the request is 32+b. On-board clear writes for other indices leave the request unchanged.
- R11: A map write with bit 31 = 0 clears the request when the request belongs to that register (slot map at 0xC00+8*g, on-board map at 0x1000+8*b). The same write for any other register leaves the request unchanged.
- R12: On the edge after a clear, the dispatcher rescans the pending lines and may issue another request.
- R13: Read data appears on the edge after a read strobe and holds while no read is made. Clear addresses and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 64 | Level interrupt lines: 0..31 slot, 32..63 on-board |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| vec_out | output | 64 | One line per interrupt vector |

## Verification
An input line is registered on the first rising edge. The request is updated on the second, so a vector output is checked at the falling edge two edges after the line changes. A register write takes effect on its own edge: the enable and any clear are visible at the falling edge that follows the write. A rescan after a clear shows one edge later. Read data is sampled at the falling edge after the strobe edge. The bench drives every stimulus on a falling edge and counts these edges before each check. It sweeps all 64 sources through enable, request, hold and clear with computed addresses, then probes preemption, priority and non-matching clears.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned RegAddrW = 16;
  localparam int unsigned RegDataW = 32;
  localparam int unsigned EnBit    = 31;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_SLOT_MAP,
    WIN_BOARD_MAP,
    WIN_SLOT_CLR,
    WIN_BOARD_CLR
  } win_e;

  function automatic win_e decode_window(input logic [RegAddrW-1:0] a);
    win_e w;
    w = WIN_NONE;
    if (a[15:6] == 10'h030)     w = WIN_SLOT_MAP;   // 0x0C00..0x0C3F
    else if (a[15:8] == 8'h10)  w = WIN_BOARD_MAP;  // 0x1000..0x10FF
    else if (a[15:8] == 8'h14)  w = WIN_SLOT_CLR;   // 0x1400..0x14FF
    else if (a[15:8] == 8'h18)  w = WIN_BOARD_CLR;  // 0x1800..0x18FF
    return w;
  endfunction
endpackage

// File: rtl/irqd_map_bank.sv
module irqd_map_bank
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SLOT_GRP = 8,
  parameter int unsigned GRP_SIZE     = 4,
  parameter int unsigned NUM_BOARD    = 32,
  localparam int unsigned SGW  = $clog2(NUM_SLOT_GRP),
  localparam int unsigned BW   = $clog2(NUM_BOARD),
  localparam int unsigned NSLOT = NUM_SLOT_GRP * GRP_SIZE,
  localparam int unsigned NSRC  = NSLOT + NUM_BOARD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [RegAddrW-1:0] addr,
  input  logic [RegDataW-1:0] wdata,
  output logic [RegDataW-1:0] rdata,
  output logic [NSRC-1:0]     en_src,
  output logic [NSRC-1:0]     en_nxt,
  output logic                dis_slot_v,
  output logic [SGW-1:0]      dis_slot_grp,
  output logic                dis_board_v,
  output logic [BW-1:0]       dis_board_idx,
  output logic                clr_slot_v,
  output logic [SGW-1:0]      clr_slot_grp,
  output logic                clr_board_v,
  output logic [BW-1:0]       clr_board_idx
);
  localparam int unsigned GW = $clog2(GRP_SIZE);

  win_e                  win;
  logic [SGW-1:0]        smap_idx;
  logic [BW-1:0]         bmap_idx;
  logic [NUM_SLOT_GRP-1:0] sen_q, sen_d;
  logic [NUM_BOARD-1:0]    ben_q, ben_d;
  logic [RegDataW-1:0]   rdata_d, rdata_q;
  logic                  unused_bits;

  assign win      = decode_window(addr);
  assign smap_idx = addr[3 +: SGW];
  assign bmap_idx = addr[3 +: BW];
  assign unused_bits = ^{addr[2:0], wdata[EnBit-1:0]};

  // Only the enable bit is stored; the other fields are fixed patterns.
  for (genvar g = 0; g < NUM_SLOT_GRP; g++) begin : g_slot_en
    assign sen_d[g] = (wr_en && win == WIN_SLOT_MAP && smap_idx == SGW'(g))
                      ? wdata[EnBit] : sen_q[g];
    for (genvar k = 0; k < GRP_SIZE; k++) begin : g_src
      assign en_src[g*GRP_SIZE + k] = sen_q[g];
      assign en_nxt[g*GRP_SIZE + k] = sen_d[g];
    end
  end

  for (genvar b = 0; b < NUM_BOARD; b++) begin : g_board_en
    assign ben_d[b] = (wr_en && win == WIN_BOARD_MAP && bmap_idx == BW'(b))
                      ? wdata[EnBit] : ben_q[b];
    assign en_src[NSLOT + b] = ben_q[b];
    assign en_nxt[NSLOT + b] = ben_d[b];
  end

  // Events that may retire the outstanding request
  always_comb begin
    dis_slot_v    = wr_en && (win == WIN_SLOT_MAP)  && !wdata[EnBit];
    dis_slot_grp  = smap_idx;
    dis_board_v   = wr_en && (win == WIN_BOARD_MAP) && !wdata[EnBit];
    dis_board_idx = bmap_idx;
    clr_slot_v    = wr_en && (win == WIN_SLOT_CLR);
    clr_slot_grp  = addr[5 +: SGW];
    clr_board_v   = wr_en && (win == WIN_BOARD_CLR);
    clr_board_idx = addr[3 +: BW];
  end

  always_comb begin
    rdata_d = '0;
    unique case (win)
      WIN_SLOT_MAP: begin
        rdata_d = 32'h0000_07C0 | (RegDataW'(smap_idx) << GW);
        rdata_d[EnBit] = sen_q[smap_idx];
      end
      WIN_BOARD_MAP: begin
        rdata_d = 32'h0000_07E0 + RegDataW'(bmap_idx);
        rdata_d[EnBit] = ben_q[bmap_idx];
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_q <= '0;
      ben_q <= '0;
    end else begin
      sen_q <= sen_d;
      ben_q <= ben_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R13: read data only moves on a read strobe
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch #(
  parameter int unsigned NUM_SLOT_GRP = 8,
  parameter int unsigned GRP_SIZE     = 4,
  parameter int unsigned NUM_BOARD    = 32,
  localparam int unsigned SGW   = $clog2(NUM_SLOT_GRP),
  localparam int unsigned BW    = $clog2(NUM_BOARD),
  localparam int unsigned NSLOT = NUM_SLOT_GRP * GRP_SIZE,
  localparam int unsigned NSRC  = NSLOT + NUM_BOARD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] en_nxt,
  input  logic            dis_slot_v,
  input  logic [SGW-1:0]  dis_slot_grp,
  input  logic            dis_board_v,
  input  logic [BW-1:0]   dis_board_idx,
  input  logic            clr_slot_v,
  input  logic [SGW-1:0]  clr_slot_grp,
  input  logic            clr_board_v,
  input  logic [BW-1:0]   clr_board_idx,
  output logic [NSRC-1:0] vec_out
);
  localparam int unsigned GW    = $clog2(GRP_SIZE);
  localparam int unsigned REQ_W = $clog2(NSRC + 1);
  localparam int unsigned SCW   = $clog2(NSRC);
  localparam int unsigned ECW   = $clog2(NSLOT);
  localparam logic [REQ_W-1:0] NoReq = REQ_W'(NSRC);

  logic [NSRC-1:0]  pend_q, pend_prev_q;
  logic [REQ_W-1:0] req_q, req_d;
  logic             req_valid, req_is_slot, req_is_board, hit;
  logic [SGW-1:0]   req_grp;
  logic [BW-1:0]    req_bidx;
  logic             scan_found, edge_found;
  logic [SCW-1:0]   scan_idx;
  logic [ECW-1:0]   edge_idx;
  logic [NSLOT-1:0] slot_rise;

  assign slot_rise = pend_q[NSLOT-1:0] & ~pend_prev_q[NSLOT-1:0] & en_nxt[NSLOT-1:0];

  irqd_prio_pick #(.N(NSRC)) u_scan_pick (
    .cand  (pend_q & en_nxt),
    .found (scan_found),
    .idx   (scan_idx)
  );

  irqd_prio_pick #(.N(NSLOT)) u_edge_pick (
    .cand  (slot_rise),
    .found (edge_found),
    .idx   (edge_idx)
  );

  always_comb begin
    req_valid    = (req_q != NoReq);
    req_is_slot  = req_valid && (req_q < REQ_W'(NSLOT));
    req_is_board = req_valid && !req_is_slot;
    req_grp      = req_q[GW +: SGW];
    req_bidx     = BW'(req_q - REQ_W'(NSLOT));
    hit = (req_is_slot  && ((dis_slot_v  && dis_slot_grp  == req_grp) ||
                            (clr_slot_v  && clr_slot_grp  == req_grp))) ||
          (req_is_board && ((dis_board_v && dis_board_idx == req_bidx) ||
                            (clr_board_v && clr_board_idx == req_bidx)));
  end

  always_comb begin
    if (hit)                      req_d = NoReq;
    else if (req_valid && edge_found) req_d = REQ_W'(edge_idx);
    else if (req_valid)           req_d = req_q;
    else if (scan_found)          req_d = REQ_W'(scan_idx);
    else                          req_d = NoReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      pend_prev_q <= '0;
      req_q       <= NoReq;
    end else begin
      pend_q      <= irq_in;
      pend_prev_q <= pend_q;
      req_q       <= req_d;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_vec
    assign vec_out[i] = (req_q == REQ_W'(i));
  end

  // R3: never more than one vector line
  p_onehot_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_out));

  // R9: a matching clear empties the slot on the next edge
  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (vec_out == '0));

  // R8: an outstanding request is held while nothing retires or preempts it
  p_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !edge_found) |=> $stable(vec_out));

  // R7: a rising on-board line alone never moves the request
  p_board_nopreempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !edge_found &&
     ((pend_q[NSRC-1:NSLOT] & ~pend_prev_q[NSRC-1:NSLOT]) != '0))
    |=> $stable(vec_out));

endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SLOT_GRP = 8,
  parameter int unsigned GRP_SIZE     = 4,
  parameter int unsigned NUM_BOARD    = 32
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [NUM_SLOT_GRP*GRP_SIZE+NUM_BOARD-1:0] irq_in,
  input  logic                                       reg_wr_en,
  input  logic                                       reg_rd_en,
  input  logic [RegAddrW-1:0]                        reg_addr,
  input  logic [RegDataW-1:0]                        reg_wdata,
  output logic [RegDataW-1:0]                        reg_rdata,
  output logic [NUM_SLOT_GRP*GRP_SIZE+NUM_BOARD-1:0] vec_out
);
  localparam int unsigned SGW  = $clog2(NUM_SLOT_GRP);
  localparam int unsigned BW   = $clog2(NUM_BOARD);
  localparam int unsigned NSRC = NUM_SLOT_GRP * GRP_SIZE + NUM_BOARD;

  logic            rst_meta_n, rst_sync_n;
  logic [NSRC-1:0] en_src, en_nxt;
  logic            dis_slot_v, dis_board_v, clr_slot_v, clr_board_v;
  logic [SGW-1:0]  dis_slot_grp, clr_slot_grp;
  logic [BW-1:0]   dis_board_idx, clr_board_idx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  irqd_map_bank #(
    .NUM_SLOT_GRP (NUM_SLOT_GRP),
    .GRP_SIZE     (GRP_SIZE),
    .NUM_BOARD    (NUM_BOARD)
  ) u_map (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (reg_wr_en),
    .rd_en         (reg_rd_en),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .rdata         (reg_rdata),
    .en_src        (en_src),
    .en_nxt        (en_nxt),
    .dis_slot_v    (dis_slot_v),
    .dis_slot_grp  (dis_slot_grp),
    .dis_board_v   (dis_board_v),
    .dis_board_idx (dis_board_idx),
    .clr_slot_v    (clr_slot_v),
    .clr_slot_grp  (clr_slot_grp),
    .clr_board_v   (clr_board_v),
    .clr_board_idx (clr_board_idx)
  );

  irqd_dispatch #(
    .NUM_SLOT_GRP (NUM_SLOT_GRP),
    .GRP_SIZE     (GRP_SIZE),
    .NUM_BOARD    (NUM_BOARD)
  ) u_disp (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .irq_in        (irq_in),
    .en_nxt        (en_nxt),
    .dis_slot_v    (dis_slot_v),
    .dis_slot_grp  (dis_slot_grp),
    .dis_board_v   (dis_board_v),
    .dis_board_idx (dis_board_idx),
    .clr_slot_v    (clr_slot_v),
    .clr_slot_grp  (clr_slot_grp),
    .clr_board_v   (clr_board_v),
    .clr_board_idx (clr_board_idx),
    .vec_out       (vec_out)
  );

  // R11: the issued vector always belongs to an enabled source
  p_req_enabled_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_out & ~en_src) == '0);

endmodule

// File: tb/irq_vector_dispatch_tb.sv
module irq_vector_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] vec_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_dispatch u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .vec_out   (vec_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  // input sampled on first edge, request on second
  task automatic drive_irq(input logic [63:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(2);
    chk("R1 vec during reset", vec_out, 64'h0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 vec after reset", vec_out, 64'h0);
    for (int g = 0; g < 8; g++)
      rd_chk("R1 slot map reset", 16'(16'h0C00 + 8*g), 32'h7C0 | 32'(g << 2));
    for (int b = 0; b < 32; b++)
      rd_chk("R1 board map reset", 16'(16'h1000 + 8*b), 32'h7E0 + 32'(b));

    // R13: clear and unmapped addresses read zero
    rd_chk("R13 slot clear reads 0", 16'h1400, 32'h0);
    rd_chk("R13 unmapped reads 0", 16'h0200, 32'h0);

    // Sweep every source
    for (int i = 0; i < 64; i++) begin
      logic [15:0] en_a, clr_a;
      logic [63:0] bit_i;
      bit_i = 64'h1 << i;
      if (i < 32) begin
        en_a  = 16'(16'h0C00 + 8*(i/4));
        clr_a = 16'(16'h1400 + 32*(i/4));
      end else begin
        en_a  = 16'(16'h1000 + 8*(i-32));
        clr_a = 16'(16'h1800 + 8*(i-32));
      end
      drive_irq(bit_i);
      chk("R4 disabled source ignored", vec_out, 64'h0);
      drive_irq(64'h0);
      wr(en_a, 32'h8000_0000);
      drive_irq(bit_i);
      chk("R4 R3 enabled source issued", vec_out, bit_i);
      drive_irq(64'h0);
      chk("R8 held after line drops", vec_out, bit_i);
      wr(clr_a, 32'h0);
      if (i < 32) chk("R9 slot clear", vec_out, 64'h0);
      else        chk("R10 board clear", vec_out, 64'h0);
      idle(2);
      chk("R12 rescan finds nothing", vec_out, 64'h0);
      wr(en_a, 32'h0);
    end

    // R2: only the enable bit is writable
    wr(16'h0C28, 32'hFFFF_FFFF);
    rd_chk("R2 slot map set", 16'h0C28, 32'h8000_07D4);
    wr(16'h0C28, 32'h0);
    rd_chk("R2 slot map cleared", 16'h0C28, 32'h0000_07D4);
    wr(16'h1018, 32'h7FFF_FFFF);
    rd_chk("R2 board map enable 0", 16'h1018, 32'h0000_07E3);
    wr(16'h1018, 32'hFFFF_FFFF);
    rd_chk("R2 board map enable 1", 16'h1018, 32'h8000_07E3);

    // enables: groups 0,1 and board 3, 8
    wr(16'h0C00, 32'h8000_0000);
    wr(16'h0C08, 32'h8000_0000);
    wr(16'h1040, 32'h8000_0000);

    // R5: lowest on-board line wins
    drive_irq((64'h1 << 35) | (64'h1 << 40));
    chk("R5 lowest on-board", vec_out, 64'h1 << 35);
    chk("R13 rdata held", {32'h0, reg_rdata}, 64'h8000_07E3);

    // R12: clear while line still high, rescan reissues
    wr(16'h1818, 32'h0);
    chk("R10 clear with line high", vec_out, 64'h0);
    idle(1);
    chk("R12 rescan reissues", vec_out, 64'h1 << 35);

    // R6: slot rise preempts
    drive_irq((64'h1 << 35) | (64'h1 << 40) | (64'h1 << 6));
    chk("R6 slot preempts", vec_out, 64'h1 << 6);

    // R7: board rise does not preempt
    wr(16'h1048, 32'h8000_0000);
    drive_irq((64'h1 << 35) | (64'h1 << 40) | (64'h1 << 6) | (64'h1 << 41));
    chk("R7 board no preempt", vec_out, 64'h1 << 6);

    // R11: disable write retires the request, then rescan
    wr(16'h0C08, 32'h0);
    chk("R11 disable retires", vec_out, 64'h0);
    idle(1);
    chk("R12 rescan after disable", vec_out, 64'h1 << 35);

    // R9 R10 R11: non-matching writes ignored
    wr(16'h1400, 32'h0);
    chk("R9 other slot group clear ignored", vec_out, 64'h1 << 35);
    wr(16'h1820, 32'h0);
    chk("R10 other board clear ignored", vec_out, 64'h1 << 35);
    wr(16'h1040, 32'h0);
    chk("R11 other disable ignored", vec_out, 64'h1 << 35);

    // R5: slot before board from empty slot
    drive_irq(64'h0);
    wr(16'h1818, 32'h0);
    idle(1);
    chk("R10 empty before priority", vec_out, 64'h0);
    drive_irq((64'h1 << 35) | (64'h1 << 3) | (64'h1 << 1));
    chk("R5 slot before board", vec_out, 64'h1 << 1);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears vec", vec_out, 64'h0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    chk("R1 vec after second reset", vec_out, 64'h0);
    rd_chk("R1 enable cleared by reset", 16'h0C00, 32'h0000_07C0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule